// File: doc/BRIEF.md
# Processor Exception Entry Controller

This block decides, in the cycle a take strobe is raised, whether the processor enters an exception, interrupt or break handler, and performs the whole architectural state update for that entry in a single clock edge. Five request lines come in: memory-management fault, hardware exception, hardware break, software break and external interrupt. The core also supplies its current PC, machine status word, the exception cause bits it wants recorded, the pending branch target and three instruction-state flags: delay slot, after an immediate prefix, and a branch that carried an immediate prefix.

At most one event is accepted per strobe, chosen by a fixed priority. The registered outputs give the redirected PC, the updated status word, the exception status word, the branch target register and one link-register write (index and data). A one-cycle `taken_q` pulse with an event code tells the core to flush its delay-slot and immediate-prefix flags. Without an accepted event every registered output holds.

Event classes, each a distinct path through the update logic: NONE (no entry, hold), MMU (fault entry), HWX (hardware exception entry), HBRK (hardware break entry), SBRK (software break entry) and IRQ (interrupt entry). Each strobe takes a single transition. It goes from the running state to the chosen class's entry update, or stays in hold when no qualified request exists.

Top module: `exc_entry_ctrl`

## Requirements
- R1: Registers update only at a rising edge where `take` is 1 and at least one qualified request exists. Otherwise `pc_q`, `msr_q`, `esr_q` and `btr_q` hold, and `taken_q` and `lr_we` are 0 in the following cycle.
- R2: When several requests are present, exactly one is accepted, in the order MMU fault, hardware exception, hardware break, software break, interrupt.
- R3: An interrupt is qualified only when status bit 1 (interrupt enable) is 1, bit 9 (exception in progress) and bit 3 (break in progress) are 0, and neither the delay-slot nor the immediate-prefix flag is set.
- R4: On every accepted event, status bit 13 (virtual mode) is copied to bit 14 and bit 11 (user mode) to bit 12, and bits 13 and 11 are then cleared. All other status bits pass from `msr_in` except the ones the event sets or clears.
- R5: A hardware exception writes PC+4 to link register 17, sets status bit 9 and redirects to `base_vec` + 0x20.
- R6: An MMU fault sets status bit 9 and redirects to `base_vec` + 0x20. It writes to link register 17 the PC minus 8 when in a delay slot of an immediate-prefixed branch, minus 4 when in any other delay slot, minus 4 when outside a delay slot with the immediate-prefix flag set, and the PC unchanged otherwise.
- R7: On a hardware exception or MMU fault, `esr_q` takes `esr_in` with bit 12 replaced by the delay-slot flag. In a delay slot `btr_q` takes `btarget_in`; otherwise `btr_q` holds. Breaks and interrupts leave both unchanged.
- R8: An interrupt writes PC to link register 14, clears status bit 1 and redirects to `base_vec` + 0x10.
- R9: A hardware break writes PC to link register 16, sets status bit 3 and redirects to `base_vec` + 0x18. A software break sets status bit 3, redirects to `btarget_in` and writes no link register.
- R10: With `cfg_exc_en` at 0 the hardware exception request is not qualified. It causes no entry and lets a lower-priority request through.
- R11: A synchronous reset sets `pc_q` to `base_vec` and clears `msr_q`, `esr_q`, `btr_q`, `lr_we` and `taken_q`.
- R12: The cycle after an accepted event, `taken_q` is 1 (flush delay-slot and immediate-prefix flags) and `ev_q` gives the class: 0 none, 1 MMU fault, 2 hardware exception, 3 hardware break, 4 software break, 5 interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| take | input | 1 | Take strobe: evaluate requests this cycle |
| cfg_exc_en | input | 1 | Configuration: hardware exceptions present |
| req_mmu | input | 1 | Memory-management fault request |
| req_hwx | input | 1 | Hardware exception request |
| req_hbrk | input | 1 | Hardware break request |
| req_sbrk | input | 1 | Software break request |
| req_irq | input | 1 | External interrupt request |
| pc_in | input | XLEN | Current PC |
| msr_in | input | XLEN | Current machine status word |
| esr_in | input | XLEN | Cause bits to record on exception entry |
| btarget_in | input | XLEN | Pending branch target |
| in_dslot | input | 1 | Instruction is in a delay slot |
| in_imm | input | 1 | Instruction follows an immediate prefix |
| in_bimm | input | 1 | Delay-slot branch carried an immediate prefix |
| base_vec | input | XLEN | Vector base address |
| pc_q | output | XLEN | Redirected PC |
| msr_q | output | XLEN | Updated status word |
| esr_q | output | XLEN | Exception status word |
| btr_q | output | XLEN | Branch target register |
| lr_we | output | 1 | Link register write enable |
| lr_idx | output | LRW | Link register index |
| lr_data | output | XLEN | Link register write data |
| taken_q | output | 1 | Entry performed; flush instruction-state flags |
| ev_q | output | 3 | Class of the accepted event |

## Verification
The functions that most often share a cycle are interrupt qualification and a higher-priority synchronous event. An MMU fault, a hardware exception or a break can arrive in the same strobe as an interrupt whose enable, in-progress and instruction-state conditions may or may not hold. The bench provokes this by sweeping every combination of the five request lines against every pattern of the qualifying status bits and instruction flags, with the strobe and the exception configuration both on and off. In each cycle it predicts the winning class, the link write and the status update arithmetically, and compares all registered outputs, including holds, against that prediction.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

    typedef enum logic [2:0] {
        EV_NONE = 3'd0,
        EV_MMU  = 3'd1,
        EV_HWX  = 3'd2,
        EV_HBRK = 3'd3,
        EV_SBRK = 3'd4,
        EV_IRQ  = 3'd5
    } ev_e;

    // status word bit positions
    localparam int ST_IE  = 1;
    localparam int ST_BIP = 3;
    localparam int ST_EIP = 9;
    localparam int ST_UM  = 11;
    localparam int ST_UMS = 12;
    localparam int ST_VM  = 13;
    localparam int ST_VMS = 14;

    // exception status: delay-slot marker
    localparam int XS_DS = 12;

    // vector offsets
    localparam int OFS_IRQ  = 'h10;
    localparam int OFS_HBRK = 'h18;
    localparam int OFS_EXC  = 'h20;

    // link register numbers
    localparam int LNK_IRQ  = 14;
    localparam int LNK_HBRK = 16;
    localparam int LNK_EXC  = 17;

endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
    import exc_entry_pkg::*;
(
    input  logic req_mmu,
    input  logic req_hwx,
    input  logic req_hbrk,
    input  logic req_sbrk,
    input  logic req_irq,
    input  logic cfg_exc_en,
    input  logic st_ie,
    input  logic st_eip,
    input  logic st_bip,
    input  logic in_dslot,
    input  logic in_imm,
    output ev_e  ev
);
    logic irq_ok;
    logic hwx_ok;

    assign irq_ok = req_irq && st_ie && !st_eip && !st_bip && !in_dslot && !in_imm;
    assign hwx_ok = req_hwx && cfg_exc_en;

    always_comb begin
        if (req_mmu)       ev = EV_MMU;
        else if (hwx_ok)   ev = EV_HWX;
        else if (req_hbrk) ev = EV_HBRK;
        else if (req_sbrk) ev = EV_SBRK;
        else if (irq_ok)   ev = EV_IRQ;
        else               ev = EV_NONE;
    end
endmodule

// File: rtl/exc_update.sv
module exc_update
    import exc_entry_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int LRW  = 5
) (
    input  ev_e              ev,
    input  logic [XLEN-1:0]  pc_in,
    input  logic [XLEN-1:0]  msr_in,
    input  logic [XLEN-1:0]  esr_in,
    input  logic [XLEN-1:0]  btarget_in,
    input  logic             in_dslot,
    input  logic             in_imm,
    input  logic             in_bimm,
    input  logic [XLEN-1:0]  base_vec,
    output logic [XLEN-1:0]  nxt_pc,
    output logic [XLEN-1:0]  nxt_msr,
    output logic [XLEN-1:0]  nxt_esr,
    output logic             upd_esr,
    output logic             upd_btr,
    output logic             nxt_lr_we,
    output logic [LRW-1:0]   nxt_lr_idx,
    output logic [XLEN-1:0]  nxt_lr_data
);
    logic [XLEN-1:0] mode_sh;
    logic [XLEN-1:0] fault_back;
    logic [XLEN-1:0] exc_esr;

    always_comb begin
        mode_sh         = msr_in;
        mode_sh[ST_VMS] = msr_in[ST_VM];
        mode_sh[ST_UMS] = msr_in[ST_UM];
        mode_sh[ST_VM]  = 1'b0;
        mode_sh[ST_UM]  = 1'b0;
    end

    always_comb begin
        if (in_dslot)    fault_back = in_bimm ? XLEN'(8) : XLEN'(4);
        else if (in_imm) fault_back = XLEN'(4);
        else             fault_back = '0;
    end

    always_comb begin
        exc_esr        = esr_in;
        exc_esr[XS_DS] = in_dslot;
    end

    always_comb begin
        nxt_pc      = pc_in;
        nxt_msr     = mode_sh;
        nxt_esr     = exc_esr;
        upd_esr     = 1'b0;
        upd_btr     = 1'b0;
        nxt_lr_we   = 1'b0;
        nxt_lr_idx  = '0;
        nxt_lr_data = '0;
        unique case (ev)
            EV_MMU: begin
                nxt_pc          = base_vec + XLEN'(OFS_EXC);
                nxt_msr[ST_EIP] = 1'b1;
                upd_esr         = 1'b1;
                upd_btr         = in_dslot;
                nxt_lr_we       = 1'b1;
                nxt_lr_idx      = LRW'(LNK_EXC);
                nxt_lr_data     = pc_in - fault_back;
            end
            EV_HWX: begin
                nxt_pc          = base_vec + XLEN'(OFS_EXC);
                nxt_msr[ST_EIP] = 1'b1;
                upd_esr         = 1'b1;
                upd_btr         = in_dslot;
                nxt_lr_we       = 1'b1;
                nxt_lr_idx      = LRW'(LNK_EXC);
                nxt_lr_data     = pc_in + XLEN'(4);
            end
            EV_HBRK: begin
                nxt_pc          = base_vec + XLEN'(OFS_HBRK);
                nxt_msr[ST_BIP] = 1'b1;
                nxt_lr_we       = 1'b1;
                nxt_lr_idx      = LRW'(LNK_HBRK);
                nxt_lr_data     = pc_in;
            end
            EV_SBRK: begin
                nxt_pc          = btarget_in;
                nxt_msr[ST_BIP] = 1'b1;
            end
            EV_IRQ: begin
                nxt_pc          = base_vec + XLEN'(OFS_IRQ);
                nxt_msr[ST_IE]  = 1'b0;
                nxt_lr_we       = 1'b1;
                nxt_lr_idx      = LRW'(LNK_IRQ);
                nxt_lr_data     = pc_in;
            end
            default: begin
                nxt_msr = msr_in;
            end
        endcase
    end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_entry_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int LRW  = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             take,
    input  logic             cfg_exc_en,
    input  logic             req_mmu,
    input  logic             req_hwx,
    input  logic             req_hbrk,
    input  logic             req_sbrk,
    input  logic             req_irq,
    input  logic [XLEN-1:0]  pc_in,
    input  logic [XLEN-1:0]  msr_in,
    input  logic [XLEN-1:0]  esr_in,
    input  logic [XLEN-1:0]  btarget_in,
    input  logic             in_dslot,
    input  logic             in_imm,
    input  logic             in_bimm,
    input  logic [XLEN-1:0]  base_vec,
    output logic [XLEN-1:0]  pc_q,
    output logic [XLEN-1:0]  msr_q,
    output logic [XLEN-1:0]  esr_q,
    output logic [XLEN-1:0]  btr_q,
    output logic             lr_we,
    output logic [LRW-1:0]   lr_idx,
    output logic [XLEN-1:0]  lr_data,
    output logic             taken_q,
    output logic [2:0]       ev_q
);
    ev_e             ev;
    logic            accept;
    logic [XLEN-1:0] nxt_pc;
    logic [XLEN-1:0] nxt_msr;
    logic [XLEN-1:0] nxt_esr;
    logic            upd_esr;
    logic            upd_btr;
    logic            nxt_lr_we;
    logic [LRW-1:0]  nxt_lr_idx;
    logic [XLEN-1:0] nxt_lr_data;

    exc_arbiter u_arb (
        .req_mmu    (req_mmu),
        .req_hwx    (req_hwx),
        .req_hbrk   (req_hbrk),
        .req_sbrk   (req_sbrk),
        .req_irq    (req_irq),
        .cfg_exc_en (cfg_exc_en),
        .st_ie      (msr_in[ST_IE]),
        .st_eip     (msr_in[ST_EIP]),
        .st_bip     (msr_in[ST_BIP]),
        .in_dslot   (in_dslot),
        .in_imm     (in_imm),
        .ev         (ev)
    );

    exc_update #(.XLEN(XLEN), .LRW(LRW)) u_upd (
        .ev          (ev),
        .pc_in       (pc_in),
        .msr_in      (msr_in),
        .esr_in      (esr_in),
        .btarget_in  (btarget_in),
        .in_dslot    (in_dslot),
        .in_imm      (in_imm),
        .in_bimm     (in_bimm),
        .base_vec    (base_vec),
        .nxt_pc      (nxt_pc),
        .nxt_msr     (nxt_msr),
        .nxt_esr     (nxt_esr),
        .upd_esr     (upd_esr),
        .upd_btr     (upd_btr),
        .nxt_lr_we   (nxt_lr_we),
        .nxt_lr_idx  (nxt_lr_idx),
        .nxt_lr_data (nxt_lr_data)
    );

    assign accept = take && (ev != EV_NONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q    <= base_vec;
            msr_q   <= '0;
            esr_q   <= '0;
            btr_q   <= '0;
            lr_we   <= 1'b0;
            lr_idx  <= '0;
            lr_data <= '0;
            taken_q <= 1'b0;
            ev_q    <= EV_NONE;
        end else begin
            lr_we   <= accept && nxt_lr_we;
            taken_q <= accept;
            ev_q    <= accept ? ev : EV_NONE;
            if (accept) begin
                pc_q    <= nxt_pc;
                msr_q   <= nxt_msr;
                lr_idx  <= nxt_lr_idx;
                lr_data <= nxt_lr_data;
                if (upd_esr) esr_q <= nxt_esr;
                if (upd_btr) btr_q <= btarget_in;
            end
        end
    end

    // R1
    hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!take) |=> ($stable(pc_q) && $stable(msr_q) && !taken_q && !lr_we));

    // R2
    prio_mmu_chk: assert property (@(posedge clk) disable iff (rst)
        (take && req_mmu) |=> (ev_q == EV_MMU));

    // R3
    irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (take && (!msr_in[ST_IE] || in_dslot || in_imm)) |=> (ev_q != EV_IRQ));

    // R4
    mode_shift_chk: assert property (@(posedge clk) disable iff (rst)
        (take && ev != EV_NONE) |=>
            (msr_q[ST_VMS] == $past(msr_in[ST_VM]) && msr_q[ST_UMS] == $past(msr_in[ST_UM])
             && !msr_q[ST_VM] && !msr_q[ST_UM]));

    // R10
    hwx_off_chk: assert property (@(posedge clk) disable iff (rst)
        (take && req_hwx && !cfg_exc_en && !req_mmu && !req_hbrk && !req_sbrk && !req_irq)
            |=> !taken_q);

    // R12
    pulse_chk: assert property (@(posedge clk) disable iff (rst)
        taken_q |-> (ev_q != EV_NONE));
endmodule

// File: tb/exc_entry_ctrl_bench.sv
`timescale 1ns/1ps
module exc_entry_ctrl_bench;
    localparam int XLEN = 32;
    localparam int LRW  = 5;
    localparam logic [31:0] BASE = 32'h8000_0000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic take = 1'b0, cfg_exc_en = 1'b0;
    logic req_mmu = 0, req_hwx = 0, req_hbrk = 0, req_sbrk = 0, req_irq = 0;
    logic [31:0] pc_in = 0, msr_in = 0, esr_in = 0, btarget_in = 0;
    logic in_dslot = 0, in_imm = 0, in_bimm = 0;
    logic [31:0] base_vec = BASE;
    logic [31:0] pc_q, msr_q, esr_q, btr_q, lr_data;
    logic lr_we, taken_q;
    logic [LRW-1:0] lr_idx;
    logic [2:0] ev_q;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    exc_entry_ctrl #(.XLEN(XLEN), .LRW(LRW)) u_exc_entry_ctrl (
        .clk(clk), .rst(rst), .take(take), .cfg_exc_en(cfg_exc_en),
        .req_mmu(req_mmu), .req_hwx(req_hwx), .req_hbrk(req_hbrk),
        .req_sbrk(req_sbrk), .req_irq(req_irq),
        .pc_in(pc_in), .msr_in(msr_in), .esr_in(esr_in), .btarget_in(btarget_in),
        .in_dslot(in_dslot), .in_imm(in_imm), .in_bimm(in_bimm), .base_vec(base_vec),
        .pc_q(pc_q), .msr_q(msr_q), .esr_q(esr_q), .btr_q(btr_q),
        .lr_we(lr_we), .lr_idx(lr_idx), .lr_data(lr_data),
        .taken_q(taken_q), .ev_q(ev_q)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    // bench model of the registered state
    logic [31:0] e_pc, e_msr, e_esr, e_btr;

    task automatic check_reset();
        chk("R11", "pc", pc_q, BASE);
        chk("R11", "msr", msr_q, 0);
        chk("R11", "esr", esr_q, 0);
        chk("R11", "btr", btr_q, 0);
        chk("R11", "lr_we", {31'b0, lr_we}, 0);
        chk("R11", "taken", {31'b0, taken_q}, 0);
        e_pc = BASE; e_msr = 0; e_esr = 0; e_btr = 0;
    endtask

    initial begin
        logic [31:0] step;
        step = 0;
        repeat (3) @(posedge clk);
        #1 check_reset();
        rst = 1'b0;
        for (int cf = 0; cf < 2; cf++)
        for (int tk = 0; tk < 2; tk++)
        for (int rq = 0; rq < 32; rq++)
        for (int fl = 0; fl < 8; fl++)
        for (int m = 0; m < 32; m++) begin
            int ev;
            int nreq;
            string tag;
            logic ds, im, bi, ie, eip, bip, vm, um;
            logic [31:0] msr, e_lr;
            logic e_we;
            int e_idx;
            ds = fl[0]; im = fl[1]; bi = fl[2];
            ie = m[0]; eip = m[1]; bip = m[2]; vm = m[3]; um = m[4];
            msr = 32'h0000_0020 | (cf ? 32'h0010_0000 : 0);
            msr[1] = ie; msr[9] = eip; msr[3] = bip; msr[13] = vm; msr[11] = um;
            msr[14] = eip; msr[12] = bip;
            step = step + 1;
            cfg_exc_en = cf[0]; take = tk[0];
            req_mmu = rq[0]; req_hwx = rq[1]; req_hbrk = rq[2]; req_sbrk = rq[3]; req_irq = rq[4];
            in_dslot = ds; in_imm = im; in_bimm = bi;
            pc_in = 32'h0001_0000 + step * 4;
            btarget_in = 32'h00A0_0000 + step * 8;
            msr_in = msr;
            esr_in = 32'h0300_0000 | {20'b0, step[11:0]} | (ds ? 32'h0 : 32'h1000);
            // prediction
            if (!tk[0]) ev = 0;
            else if (rq[0]) ev = 1;
            else if (rq[1] && cf[0]) ev = 2;
            else if (rq[2]) ev = 3;
            else if (rq[3]) ev = 4;
            else if (rq[4] && ie && !eip && !bip && !ds && !im) ev = 5;
            else ev = 0;
            nreq = int'(rq[0]) + int'(rq[1]) + int'(rq[2]) + int'(rq[3]) + int'(rq[4]);
            e_we = 0; e_idx = 0; e_lr = 0;
            if (ev != 0) begin
                e_msr = msr;
                e_msr[14] = vm; e_msr[12] = um; e_msr[13] = 0; e_msr[11] = 0;
            end
            case (ev)
                1: begin
                    e_pc = BASE + 32'h20; e_msr[9] = 1; e_we = 1; e_idx = 17;
                    e_lr = pc_in - (ds ? (bi ? 8 : 4) : (im ? 4 : 0));
                    e_esr = (esr_in & ~32'h1000) | (ds ? 32'h1000 : 0);
                    if (ds) e_btr = btarget_in;
                    tag = "R6";
                end
                2: begin
                    e_pc = BASE + 32'h20; e_msr[9] = 1; e_we = 1; e_idx = 17;
                    e_lr = pc_in + 4;
                    e_esr = (esr_in & ~32'h1000) | (ds ? 32'h1000 : 0);
                    if (ds) e_btr = btarget_in;
                    tag = "R5";
                end
                3: begin
                    e_pc = BASE + 32'h18; e_msr[3] = 1; e_we = 1; e_idx = 16; e_lr = pc_in;
                    tag = "R9";
                end
                4: begin
                    e_pc = btarget_in; e_msr[3] = 1; tag = "R9";
                end
                5: begin
                    e_pc = BASE + 32'h10; e_msr[1] = 0; e_we = 1; e_idx = 14; e_lr = pc_in;
                    tag = "R8";
                end
                default: begin
                    if (tk[0] && rq[1] && !cf[0]) tag = "R10";
                    else if (tk[0] && rq[4]) tag = "R3";
                    else tag = "R1";
                end
            endcase
            @(posedge clk);
            #1;
            chk(tag, "pc", pc_q, e_pc);
            chk("R4", "msr", msr_q, e_msr);
            chk("R7", "esr", esr_q, e_esr);
            chk("R7", "btr", btr_q, e_btr);
            chk(tag, "lr_we", {31'b0, lr_we}, {31'b0, e_we});
            if (e_we) begin
                chk(tag, "lr_idx", {27'b0, lr_idx}, e_idx);
                chk(tag, "lr_data", lr_data, e_lr);
            end
            chk((nreq > 1) ? "R2" : "R12", "ev", {29'b0, ev_q}, ev);
            chk("R12", "taken", {31'b0, taken_q}, (ev != 0) ? 1 : 0);
        end
        take = 1'b1; req_irq = 1'b1; msr_in = 32'h0000_0002; in_dslot = 0; in_imm = 0;
        rst = 1'b1;
        @(posedge clk);
        #1 check_reset();
        rst = 1'b0; take = 1'b0;
        @(posedge clk);
        #1 finish_run();
    end
endmodule